// File: doc/BRIEF.md
# Shadow-Tag Way Repartitioner

This block decides how the ways of one set-associative cache slice are split between a private region, used only by the local core, and a shared region, open to every core. The replacement logic reads the current private way count from the `priv_ways` output and limits victim selection to match. The shared region always holds the remaining ways, so the two counts always add up to the full associativity.

The decision comes from shadow tags. Each set keeps one shadow entry for each region. When a line leaves a region on replacement, its tag goes into that region's shadow entry for the set. When a later miss presents a tag that matches a valid shadow entry, the matching region gets the credit: its saturating shadow-hit counter goes up, and the entry is cleared so the same line is counted only once. A miss counter measures the length of each period. When the period is full, the two shadow-hit counts are compared, the region with more shadow hits gains one way, and every counter starts again from zero.

The control has two states. GATHER collects events. The transition "period full" is taken when the miss that completes the period is accepted. DECIDE lasts one cycle: it applies the verdict to `priv_ways` and takes the transition "verdict applied" back to GATHER. Eviction and miss events are still accepted while in DECIDE, and they count toward the new period.

Top module: `way_split_ctrl`

## Requirements
- R1: After reset, `priv_ways` equals INIT_PRIV, every shadow entry is invalid, and every counter is zero.
- R2: An eviction (`evict_vld`=1) writes `evict_tag` into the shadow entry selected by `evict_set` and `evict_part`, where `evict_part`=0 selects the private region and 1 selects the shared region.
- R3: A miss whose tag matches a valid shadow entry of its own set adds one to that region's shadow-hit count and clears the entry. A second miss on the same tag is therefore not counted.
- R4: Every accepted miss adds one to the period length. The miss that brings the length to MISS_THRESH moves the control to DECIDE. `priv_ways` changes on the clock edge that ends the DECIDE cycle and on no other edge.
- R5: In DECIDE, if the private shadow-hit count exceeds the shared count, `priv_ways` rises by one. If the shared count exceeds the private count, `priv_ways` falls by one.
- R6: If the two shadow-hit counts are equal in DECIDE, `priv_ways` stays the same.
- R7: `priv_ways` never leaves the range 1 to WAYS-1. A move that would leave the range is skipped.
- R8: DECIDE restarts the miss counter and both shadow-hit counters. A miss accepted in the DECIDE cycle becomes the first miss of the new period, along with any shadow hit it makes.
- R9: Each shadow-hit counter stops at 2^HIT_W-1 and does not wrap.
- R10: If an eviction and a matching miss fall on the same shadow entry in the same cycle, the miss is counted against the old contents and the entry then holds the evicted tag as valid.
- R11: A miss tag that matches a shadow entry of a different set is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evict_vld | input | 1 | Replacement eviction event |
| evict_tag | input | TAG_W | Tag of the evicted line |
| evict_set | input | $clog2(SETS) | Set of the evicted line |
| evict_part | input | 1 | Region of the evicted line (0 private, 1 shared) |
| miss_vld | input | 1 | Slice miss event |
| miss_tag | input | TAG_W | Tag of the missed address |
| miss_set | input | $clog2(SETS) | Set of the missed address |
| priv_ways | output | $clog2(WAYS) | Current number of private ways |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is an eviction write and a miss that invalidates the same shadow entry. The bench provokes it by evicting into an entry in the same cycle that a miss hits that entry. It then judges the result in a later period: the miss must have been counted, and a later miss on the newly evicted tag must also be counted. Only then does the private region win the comparison.

The second pair is the DECIDE verdict and the first miss of the next period. The bench places a shared-region shadow hit exactly in the DECIDE cycle. It then checks that the following verdict arrives one miss earlier than a full period, and that the verdict is a shrink.

A behavioural reference model compares `priv_ways` on every clock.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    typedef enum logic {
        PART_PRIV = 1'b0,
        PART_SHRD = 1'b1
    } part_e;

    typedef enum logic {
        ST_GATHER = 1'b0,
        ST_DECIDE = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        MV_HOLD      = 2'd0,
        MV_GROW_PRIV = 2'd1,
        MV_GROW_SHRD = 2'd2
    } move_e;

endpackage

// File: rtl/wsc_shadow_store.sv
module wsc_shadow_store #(
    parameter int SETS  = 16,
    parameter int TAG_W = 20,
    parameter int SW    = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_vld,
    input  logic [TAG_W-1:0] ev_tag,
    input  logic [SW-1:0]    ev_set,
    input  logic             ev_part,
    input  logic             lk_vld,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [SW-1:0]    lk_set,
    output logic [1:0]       lk_hit
);

    localparam int NPART = 2;

    logic [SETS-1:0]  vld_q [NPART];
    logic [TAG_W-1:0] tag_q [NPART][SETS];

    // lookup against the contents held before this cycle's write
    always_comb begin
        for (int p = 0; p < NPART; p++) begin
            lk_hit[p] = lk_vld && vld_q[p][lk_set] && (tag_q[p][lk_set] == lk_tag);
        end
    end

    // eviction write takes precedence over hit invalidation on the same entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPART; p++) begin
                vld_q[p] <= '0;
                for (int s = 0; s < SETS; s++) begin
                    tag_q[p][s] <= '0;
                end
            end
        end else begin
            for (int p = 0; p < NPART; p++) begin
                for (int s = 0; s < SETS; s++) begin
                    if (ev_vld && (ev_part == 1'(p)) && (ev_set == SW'(s))) begin
                        vld_q[p][s] <= 1'b1;
                        tag_q[p][s] <= ev_tag;
                    end else if (lk_hit[p] && (lk_set == SW'(s))) begin
                        vld_q[p][s] <= 1'b0;
                    end
                end
            end
        end
    end

    // R2
    evict_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_vld |=> (vld_q[$past(ev_part)][$past(ev_set)] &&
                    tag_q[$past(ev_part)][$past(ev_set)] == $past(ev_tag)));

    // R3
    hit_clears_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit[0] && !(ev_vld && ev_part == 1'b0 && ev_set == lk_set))
        |=> !vld_q[0][$past(lk_set)]);

    // R3
    hit_clears_shrd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit[1] && !(ev_vld && ev_part == 1'b1 && ev_set == lk_set))
        |=> !vld_q[1][$past(lk_set)]);

    // R3
    hit_needs_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit != 2'b00) |-> lk_vld);

endmodule

// File: rtl/wsc_sat_counter.sv
module wsc_sat_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         bump,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= {{(W-1){1'b0}}, bump};
        end else if (bump && (count != TOP)) begin
            count <= count + 1'b1;
        end
    end

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP && !restart) |=> count == TOP);

    // R8
    restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count <= W'(1)));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !bump) |=> $stable(count));

endmodule

// File: rtl/wsc_boundary_fsm.sv
module wsc_boundary_fsm
    import wsc_pkg::*;
#(
    parameter int WAYS        = 8,
    parameter int MISS_THRESH = 256,
    parameter int INIT_PRIV   = 4,
    parameter int HIT_W       = 6,
    parameter int PW          = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_vld,
    input  logic [HIT_W-1:0] hits_priv,
    input  logic [HIT_W-1:0] hits_shrd,
    output logic             decide,
    output logic [PW-1:0]    priv_ways
);

    localparam int MCW = $clog2(MISS_THRESH + 1);
    localparam logic [MCW-1:0] LAST_BEFORE = MCW'(MISS_THRESH - 1);
    localparam logic [PW-1:0]  CEIL_WAYS   = PW'(WAYS - 1);
    localparam logic [PW-1:0]  FLOOR_WAYS  = PW'(1);

    phase_e           state_q, state_d;
    logic [MCW-1:0]   miss_cnt_q;
    move_e            move;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_GATHER;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GATHER: if (miss_vld && miss_cnt_q == LAST_BEFORE) state_d = ST_DECIDE;
            ST_DECIDE: state_d = ST_GATHER;
        endcase
    end

    // period length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miss_cnt_q <= '0;
        end else if (state_q == ST_DECIDE) begin
            miss_cnt_q <= {{(MCW-1){1'b0}}, miss_vld};
        end else if (miss_vld) begin
            miss_cnt_q <= miss_cnt_q + 1'b1;
        end
    end

    // verdict
    always_comb begin
        move = MV_HOLD;
        if ((hits_priv > hits_shrd) && (priv_ways < CEIL_WAYS)) begin
            move = MV_GROW_PRIV;
        end else if ((hits_shrd > hits_priv) && (priv_ways > FLOOR_WAYS)) begin
            move = MV_GROW_SHRD;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            priv_ways <= PW'(INIT_PRIV);
        end else if (state_q == ST_DECIDE) begin
            unique case (move)
                MV_GROW_PRIV: priv_ways <= priv_ways + 1'b1;
                MV_GROW_SHRD: priv_ways <= priv_ways - 1'b1;
                default:      priv_ways <= priv_ways;
            endcase
        end
    end

    assign decide = (state_q == ST_DECIDE);

    // R7
    way_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_ways >= FLOOR_WAYS) && (priv_ways <= CEIL_WAYS));

    // R4
    hold_in_gather_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATHER) |=> $stable(priv_ways));

    // R4
    period_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATHER && miss_vld && miss_cnt_q == LAST_BEFORE) |=> state_q == ST_DECIDE);

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cnt_q <= MCW'(MISS_THRESH));

    // R5
    grow_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && hits_priv > hits_shrd && priv_ways < CEIL_WAYS)
        |=> priv_ways == $past(priv_ways) + 1'b1);

    // R5
    grow_shrd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && hits_shrd > hits_priv && priv_ways > FLOOR_WAYS)
        |=> priv_ways == $past(priv_ways) - 1'b1);

    // R6
    tie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && hits_priv == hits_shrd) |=> $stable(priv_ways));

    // R8
    one_cycle_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE) |=> (state_q == ST_GATHER && miss_cnt_q <= MCW'(1)));

endmodule

// File: rtl/way_split_ctrl.sv
module way_split_ctrl #(
    parameter int WAYS        = 8,
    parameter int SETS        = 16,
    parameter int TAG_W       = 20,
    parameter int MISS_THRESH = 256,
    parameter int HIT_W       = 6,
    parameter int INIT_PRIV   = 4,
    parameter int SW          = $clog2(SETS),
    parameter int PW          = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evict_vld,
    input  logic [TAG_W-1:0] evict_tag,
    input  logic [SW-1:0]    evict_set,
    input  logic             evict_part,
    input  logic             miss_vld,
    input  logic [TAG_W-1:0] miss_tag,
    input  logic [SW-1:0]    miss_set,
    output logic [PW-1:0]    priv_ways
);

    logic [1:0]            shadow_hit;
    logic [1:0][HIT_W-1:0] hit_cnt;
    logic                  decide;

    wsc_shadow_store #(
        .SETS  (SETS),
        .TAG_W (TAG_W),
        .SW    (SW)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_vld (evict_vld),
        .ev_tag (evict_tag),
        .ev_set (evict_set),
        .ev_part(evict_part),
        .lk_vld (miss_vld),
        .lk_tag (miss_tag),
        .lk_set (miss_set),
        .lk_hit (shadow_hit)
    );

    for (genvar p = 0; p < 2; p++) begin : g_hitcnt
        wsc_sat_counter #(
            .W (HIT_W)
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .restart(decide),
            .bump   (shadow_hit[p]),
            .count  (hit_cnt[p])
        );
    end

    wsc_boundary_fsm #(
        .WAYS       (WAYS),
        .MISS_THRESH(MISS_THRESH),
        .INIT_PRIV  (INIT_PRIV),
        .HIT_W      (HIT_W),
        .PW         (PW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .miss_vld (miss_vld),
        .hits_priv(hit_cnt[0]),
        .hits_shrd(hit_cnt[1]),
        .decide   (decide),
        .priv_ways(priv_ways)
    );

    // R11
    set_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_vld |=> $stable(hit_cnt) || $past(decide));

endmodule

// File: tb/way_split_ctrl_tb.sv
module way_split_ctrl_tb_top;

    localparam int WAYS   = 4;
    localparam int SETS   = 4;
    localparam int TAG_W  = 8;
    localparam int THRESH = 20;
    localparam int HIT_W  = 3;
    localparam int INIT   = 2;
    localparam int SW     = $clog2(SETS);
    localparam int PW     = $clog2(WAYS);
    localparam int HMAX   = (1 << HIT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             evict_vld = 1'b0;
    logic [TAG_W-1:0] evict_tag = '0;
    logic [SW-1:0]    evict_set = '0;
    logic             evict_part = 1'b0;
    logic             miss_vld = 1'b0;
    logic [TAG_W-1:0] miss_tag = '0;
    logic [SW-1:0]    miss_set = '0;
    logic [PW-1:0]    priv_ways;

    always #5 clk = ~clk;

    way_split_ctrl #(
        .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .MISS_THRESH(THRESH),
        .HIT_W(HIT_W), .INIT_PRIV(INIT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .evict_vld(evict_vld), .evict_tag(evict_tag), .evict_set(evict_set),
        .evict_part(evict_part), .miss_vld(miss_vld), .miss_tag(miss_tag),
        .miss_set(miss_set), .priv_ways(priv_ways)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    int m_priv = INIT;
    int m_cnt = 0;
    int m_hp = 0;
    int m_hs = 0;
    bit m_dec = 1'b0;
    bit m_sv [2][SETS];
    int m_st [2][SETS];
    int next_tag = 1;
    int fresh = 200;

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: priv_ways=%0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(bit ev, int etag, int eset, int ep, bit mv, int mtag, int mset);
        bit h0, h1;
        @(negedge clk);
        evict_vld  = ev;
        evict_tag  = TAG_W'(etag);
        evict_set  = SW'(eset);
        evict_part = ep[0];
        miss_vld   = mv;
        miss_tag   = TAG_W'(mtag);
        miss_set   = SW'(mset);
        @(posedge clk);
        #1;
        h0 = mv && m_sv[0][mset] && (m_st[0][mset] == mtag);
        h1 = mv && m_sv[1][mset] && (m_st[1][mset] == mtag);
        if (m_dec) begin
            if (m_hp > m_hs && m_priv < WAYS - 1) m_priv++;
            else if (m_hs > m_hp && m_priv > 1) m_priv--;
            m_cnt = mv ? 1 : 0;
            m_hp  = h0 ? 1 : 0;
            m_hs  = h1 ? 1 : 0;
            m_dec = 1'b0;
        end else begin
            if (mv) begin
                m_cnt++;
                if (m_cnt == THRESH) m_dec = 1'b1;
            end
            if (h0 && m_hp < HMAX) m_hp++;
            if (h1 && m_hs < HMAX) m_hs++;
        end
        if (h0) m_sv[0][mset] = 1'b0;
        if (h1) m_sv[1][mset] = 1'b0;
        if (ev) begin
            m_sv[ep][eset] = 1'b1;
            m_st[ep][eset] = etag;
        end
        check(int'(priv_ways) == m_priv, cur_req, int'(priv_ways), m_priv);
    endtask

    task automatic evict(int tag, int set, int part);
        step(1'b1, tag, set, part, 1'b0, 0, 0);
    endtask

    task automatic miss(int tag, int set);
        step(1'b0, 0, 0, 0, 1'b1, tag, set);
    endtask

    task automatic idle();
        step(1'b0, 0, 0, 0, 1'b0, 0, 0);
    endtask

    task automatic filler();
        miss(fresh, 0);
        fresh = (fresh == 255) ? 200 : fresh + 1;
    endtask

    // evict then miss the same tag: one shadow hit for the region
    task automatic credit(int part, int set);
        evict(next_tag, set, part);
        miss(next_tag, set);
        next_tag++;
    endtask

    // completes the period, runs the decide cycle, checks the verdict
    task automatic finish_period(int exp, string req);
        while (!m_dec) filler();
        check(int'(priv_ways) == m_priv, "R4", int'(priv_ways), m_priv);
        idle();
        check(int'(priv_ways) == exp, req, int'(priv_ways), exp);
    endtask

    initial begin
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < SETS; s++) begin
                m_sv[p][s] = 1'b0;
                m_st[p][s] = 0;
            end
        end
        repeat (3) @(negedge clk);
        check(int'(priv_ways) == INIT, "R1", int'(priv_ways), INIT);
        rst_n = 1'b1;
        idle();
        check(int'(priv_ways) == INIT, "R1", int'(priv_ways), INIT);

        // R2 R3 R5: private shadow hits in several sets grow the private region
        cur_req = "R5";
        credit(0, 0); credit(0, 1); credit(0, 2);
        finish_period(3, "R5");

        // R7: ceiling
        cur_req = "R7";
        credit(0, 3);
        finish_period(3, "R7");

        // R5 shrink, then floor R7
        cur_req = "R5";
        credit(1, 0); credit(1, 1);
        finish_period(2, "R5");
        credit(1, 2); credit(1, 3);
        finish_period(1, "R5");
        cur_req = "R7";
        credit(1, 0);
        finish_period(1, "R7");

        // R6: tie
        cur_req = "R6";
        credit(0, 1); credit(1, 1); credit(0, 2); credit(1, 2);
        finish_period(1, "R6");

        // R3: a matched entry is cleared, so a repeat miss is not counted
        cur_req = "R3";
        evict(next_tag, 1, 0);
        miss(next_tag, 1);
        miss(next_tag, 1);
        next_tag++;
        credit(1, 2);
        finish_period(1, "R3");

        cur_req = "R5";
        credit(0, 0); credit(0, 3);
        finish_period(2, "R5");

        // R11: a tag in another set's shadow entry does not count
        cur_req = "R11";
        evict(next_tag, 0, 0);
        miss(next_tag, 1);
        next_tag++;
        credit(1, 2);
        finish_period(1, "R11");

        // R10: same-cycle eviction and matching miss on one entry
        cur_req = "R10";
        evict(next_tag, 0, 0);
        step(1'b1, next_tag + 1, 0, 0, 1'b1, next_tag, 0);
        miss(next_tag + 1, 0);
        next_tag += 2;
        credit(1, 1);
        finish_period(2, "R10");

        // R9: both counters saturate, giving a tie
        cur_req = "R9";
        for (int i = 0; i < 9; i++) credit(0, 0);
        for (int i = 0; i < 8; i++) credit(1, 1);
        finish_period(2, "R9");

        // R8: a shared hit in the decide cycle opens the next period
        cur_req = "R8";
        credit(0, 0);
        evict(next_tag, 2, 1);
        while (!m_dec) filler();
        miss(next_tag, 2);
        next_tag++;
        check(int'(priv_ways) == 3, "R8", int'(priv_ways), 3);
        for (int i = 0; i < THRESH - 2; i++) filler();
        check(m_dec == 1'b0 && int'(priv_ways) == 3, "R8", int'(priv_ways), 3);
        filler();
        idle();
        check(int'(priv_ways) == 2, "R8", int'(priv_ways), 2);

        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: priv_ways=%0d expected completion", priv_ways);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule